// File: doc/BRIEF.md
# Multi-Port Hardware Lock Bank

A bank of single-bit hardware locks that processors use to coordinate access to shared resources. Each processor reaches the bank through its own register port. The port index is the requester ID. Every lock occupies one 32-bit word in the address map.

A read of a lock word returns the lock's previous state. If the lock was free, the same read takes it, so a processor acquires a lock with one ordinary load. A processor gives a lock back by storing zero to the lock's word. One read-only status word reports the size of the bank, coded as the lock count divided by 32 and placed at bit 24.

The bank has no notion of ownership. Any port may release any lock. When several ports read the same free lock in the same cycle, the port with the lowest index takes it. Read data is registered and appears on the port the cycle after the read strobe.

Top module: `sem_bank`

## Requirements
- R1: While reset is asserted and after it is released, every lock is free and every port's read data is 0.
- R2: A read of a free lock's word returns 0 one cycle later, and the lock is taken from then on.
- R3: A read of a taken lock's word returns 1 one cycle later, and the lock stays taken.
- R4: A write of data 0 to a lock's word frees that lock, whichever port issues it.
- R5: A write of any nonzero data to a lock's word leaves the lock unchanged.
- R6: Lock i occupies byte address 0x800 + 4*i for i below NUM_LOCKS. An address in that window that is not word aligned does not map to a lock.
- R7: A read of byte address 0x014 returns (NUM_LOCKS/32) placed at bits 31:24, with all other bits 0. Writes to that address have no effect, and reads of it claim no lock.
- R8: A read of any address that is neither a lock word nor 0x014 returns 0 and claims nothing. A write to such an address has no effect.
- R9: When several ports read the same free lock in the same cycle, the lowest-indexed of them reads 0 and takes the lock. Every other port in that group reads 1.
- R10: When one port reads a taken lock in the same cycle that another port writes 0 to it, the reader gets 1 and the lock ends up free. When one port reads a free lock in the same cycle that another port writes 0 to it, the reader gets 0 and the lock ends up taken.
- R11: In a cycle without a read strobe, a port's read data in the following cycle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd | input | NUM_PORTS | Read strobe, one bit per port |
| wr | input | NUM_PORTS | Write strobe, one bit per port |
| addr | input | NUM_PORTS*12 | Byte address, 12 bits per port, port 0 in the low bits |
| wdata | input | NUM_PORTS*32 | Write data, 32 bits per port |
| rdata | output | NUM_PORTS*32 | Registered read data, 32 bits per port |

## Verification
The assertions assume that a port never raises rd and wr in the same cycle. A port's read or write is defined only by the address it presents during that cycle. The bench drives each port through one task that raises at most one strobe, and it returns all strobes to zero between accesses. The only cycles where several ports are active are the deliberate collision cycles for the priority and read-against-release cases, and in those each port still drives a single strobe.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned ADDR_W       = 12;
    localparam logic [11:0] LOCK_BASE    = 12'h800;
    localparam logic [11:0] STATUS_ADDR  = 12'h014;
    localparam int unsigned STATUS_SHIFT = 24;

    // Size word: lock count in units of 32, placed at bit 24
    function automatic logic [31:0] status_word(input int unsigned n_locks);
        return 32'(n_locks / 32) << STATUS_SHIFT;
    endfunction
endpackage

// File: rtl/sem_decode.sv
module sem_decode
    import sem_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_lock,
    output logic              is_status,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] off;

    always_comb begin
        off       = addr - LOCK_BASE;
        is_lock   = (addr >= LOCK_BASE) && (off[1:0] == 2'b00)
                    && ({2'b00, off[ADDR_W-1:2]} < ADDR_W'(NUM_LOCKS));
        is_status = (addr == STATUS_ADDR);
        idx       = off[IDX_W+1:2];
    end
endmodule

// File: rtl/sem_arbiter.sv
module sem_arbiter #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       rd_hit,
    input  logic [NUM_PORTS-1:0]       clr_hit,
    input  logic [NUM_PORTS*IDX_W-1:0] idx_flat,
    input  logic [NUM_LOCKS-1:0]       lock_q,
    output logic [NUM_PORTS-1:0]       won,
    output logic [NUM_LOCKS-1:0]       set_vec,
    output logic [NUM_LOCKS-1:0]       clr_vec,
    output logic [NUM_LOCKS-1:0]       req_vec
);
    logic [IDX_W-1:0] idx_a [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
        assign idx_a[p] = idx_flat[p*IDX_W +: IDX_W];
    end

    // Fixed priority: a lower port index beats a higher one on the same lock
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            won[p] = rd_hit[p] && !lock_q[idx_a[p]];
            for (int q = 0; q < p; q++) begin
                if (rd_hit[q] && (idx_a[q] == idx_a[p])) won[p] = 1'b0;
            end
        end
    end

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        req_vec = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (won[p])     set_vec[idx_a[p]] = 1'b1;
            if (clr_hit[p]) clr_vec[idx_a[p]] = 1'b1;
            if (rd_hit[p])  req_vec[idx_a[p]] = 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pair
        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_other
            AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                !(won[p] && won[q] && (idx_a[p] == idx_a[q]))); // R9
            AST_LOW_PORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_hit[p] && rd_hit[q] && (idx_a[p] == idx_a[q])) |-> !won[q]); // R9
        end
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        rd,
    input  logic [NUM_PORTS-1:0]        wr,
    input  logic [NUM_PORTS*ADDR_W-1:0] addr,
    input  logic [NUM_PORTS*DATA_W-1:0] wdata,
    output logic [NUM_PORTS*DATA_W-1:0] rdata
);
    localparam int unsigned IDX_W     = $clog2(NUM_LOCKS);
    localparam logic [31:0] SIZE_WORD = status_word(NUM_LOCKS);

    typedef struct packed {
        logic [NUM_LOCKS-1:0]        locks;
        logic [NUM_PORTS*DATA_W-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_PORTS-1:0]       lock_hit, stat_hit, rd_hit, clr_hit, won;
    logic [NUM_PORTS*IDX_W-1:0] idx_flat;
    logic [IDX_W-1:0]           idx_a [NUM_PORTS];
    logic [NUM_LOCKS-1:0]       set_vec, clr_vec, req_vec;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sem_decode #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_dec (
            .addr      (addr[p*ADDR_W +: ADDR_W]),
            .is_lock   (lock_hit[p]),
            .is_status (stat_hit[p]),
            .idx       (idx_a[p])
        );
        assign idx_flat[p*IDX_W +: IDX_W] = idx_a[p];
        assign rd_hit[p]  = rd[p] && lock_hit[p];
        assign clr_hit[p] = wr[p] && lock_hit[p] && (wdata[p*DATA_W +: DATA_W] == '0);
    end

    sem_arbiter #(.NUM_LOCKS(NUM_LOCKS), .NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .clr_hit  (clr_hit),
        .idx_flat (idx_flat),
        .lock_q   (state_q.locks),
        .won      (won),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .req_vec  (req_vec)
    );

    always_comb begin
        state_d       = state_q;
        // A release drops a held lock; a claim can only land on a free one
        state_d.locks = (state_q.locks & ~clr_vec) | set_vec;
        for (int p = 0; p < NUM_PORTS; p++) begin
            state_d.rdata[p*DATA_W +: DATA_W] = '0;
            if (rd[p]) begin
                if (stat_hit[p])
                    state_d.rdata[p*DATA_W +: DATA_W] = SIZE_WORD;
                else if (lock_hit[p])
                    state_d.rdata[p*DATA_W +: DATA_W] = won[p] ? 32'd0 : 32'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rdata = state_q.rdata;

    AST_PORT0_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd[0] && lock_hit[0] && !state_q.locks[idx_a[0]]) |=> (rdata[DATA_W-1:0] == '0)); // R2

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        AST_TAKEN_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (rd[p] && lock_hit[p] && state_q.locks[idx_a[p]])
            |=> (rdata[p*DATA_W +: DATA_W] == 32'd1)); // R3
        AST_CLAIM_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd[p] && lock_hit[p] && !clr_vec[idx_a[p]])
            |=> state_q.locks[$past(idx_a[p])]); // R2
        AST_SIZE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            (rd[p] && stat_hit[p]) |=> (rdata[p*DATA_W +: DATA_W] == SIZE_WORD)); // R7
        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !rd[p] |=> (rdata[p*DATA_W +: DATA_W] == '0)); // R11
    end

    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock_chk
        AST_RISE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(state_q.locks[l]) |-> $past(req_vec[l])); // R5
        AST_FALL_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(state_q.locks[l]) |-> $past(clr_vec[l])); // R4
    end
endmodule

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
    localparam int NL = 32;
    localparam int NP = 3;
    localparam int AW = 12;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     rd = '0;
    logic [NP-1:0]     wr = '0;
    logic [NP*AW-1:0]  addr = '0;
    logic [NP*DW-1:0]  wdata = '0;
    logic [NP*DW-1:0]  rdata;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sem_bank #(.NUM_LOCKS(NL), .NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [AW-1:0] lock_addr(input int i);
        return AW'(32'h800 + 4 * i);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic put_rd(input int p, input logic [AW-1:0] a);
        rd[p] = 1'b1;
        addr[p*AW +: AW] = a;
    endtask

    task automatic put_wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr[p] = 1'b1;
        addr[p*AW +: AW] = a;
        wdata[p*DW +: DW] = d;
    endtask

    // Inputs are sampled at the next rising edge; read data is checked 2 ns after it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        rd = '0;
        wr = '0;
        addr = '0;
        wdata = '0;
    endtask

    function automatic logic [DW-1:0] port_rd(input int p);
        return rdata[p*DW +: DW];
    endfunction

    task automatic read1(input int p, input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        put_rd(p, a);
        tick();
        chk(tag, port_rd(p), exp);
        idle();
    endtask

    task automatic write1(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        put_wr(p, a, d);
        tick();
        idle();
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        $display("FAIL watchdog: got=timeout exp=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        for (int p = 0; p < NP; p++) chk("R1 reset rdata", port_rd(p), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        for (int p = 0; p < NP; p++) chk("R1 rdata after reset", port_rd(p), 0);

        // First pass claims every lock; the second pass finds each one held
        for (int i = 0; i < NL; i++) read1(0, lock_addr(i), 0, "R2 R6 free read");
        for (int i = 0; i < NL; i++) read1(1, lock_addr(i), 1, "R3 taken read");

        // Zero writes from port 1 on even locks, nonzero writes from port 2 on odd locks
        for (int i = 0; i < NL; i++) begin
            if (i % 2 == 0) write1(1, lock_addr(i), 0);
            else            write1(2, lock_addr(i), DW'(i + 1));
        end
        for (int i = 0; i < NL; i++)
            read1(2, lock_addr(i), (i % 2 == 0) ? 0 : 1, (i % 2 == 0) ? "R4 released" : "R5 nonzero write ignored");

        tick();
        for (int p = 0; p < NP; p++) chk("R11 idle rdata", port_rd(p), 0);

        // Size word: 32 locks is one unit of 32, at bit 24
        read1(1, 12'h014, DW'((NL / 32) << 24), "R7 size word");
        write1(1, 12'h014, 0);
        read1(0, 12'h014, DW'((NL / 32) << 24), "R7 size word after write");
        write1(0, lock_addr(3), 0);
        read1(2, 12'h014, DW'((NL / 32) << 24), "R7 size word again");
        read1(2, lock_addr(3), 0, "R7 size read claims nothing");

        // Unmapped writes must not free lock 0, which is held
        write1(0, 12'h801, 0);
        write1(1, 12'h880, 0);
        write1(2, 12'h000, 0);
        read1(0, lock_addr(0), 1, "R8 unmapped write ignored");
        read1(0, 12'h801, 0, "R6 R8 unaligned read");
        read1(1, 12'h880, 0, "R6 R8 past last lock");
        read1(2, 12'h7FC, 0, "R8 below window");
        read1(0, 12'h018, 0, "R8 near size word");

        // Collisions on a free lock
        write1(0, lock_addr(5), 0);
        write1(0, lock_addr(6), 0);
        put_rd(0, lock_addr(5)); put_rd(1, lock_addr(5)); put_rd(2, lock_addr(5));
        tick();
        chk("R9 port0 wins", port_rd(0), 0);
        chk("R9 port1 loses", port_rd(1), 1);
        chk("R9 port2 loses", port_rd(2), 1);
        idle();
        put_rd(1, lock_addr(6)); put_rd(2, lock_addr(6));
        tick();
        chk("R9 port1 wins", port_rd(1), 0);
        chk("R9 port2 loses", port_rd(2), 1);
        idle();
        put_rd(0, lock_addr(7)); put_rd(2, lock_addr(7));
        tick();
        chk("R9 held both lose p0", port_rd(0), 1);
        chk("R9 held both lose p2", port_rd(2), 1);
        idle();

        // Read against release in the same cycle
        put_rd(0, lock_addr(9)); put_wr(1, lock_addr(9), 0);
        tick();
        chk("R10 held read with release", port_rd(0), 1);
        idle();
        read1(0, lock_addr(9), 0, "R10 release took effect");
        write1(2, lock_addr(10), 0);
        put_rd(0, lock_addr(10)); put_wr(1, lock_addr(10), 0);
        tick();
        chk("R10 free read with release", port_rd(0), 0);
        idle();
        read1(2, lock_addr(10), 1, "R10 claim survived");

        // Reset mid-run frees everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read1(0, lock_addr(0), 0, "R1 reset frees lock 0");
        read1(1, lock_addr(NL - 1), 0, "R1 reset frees last lock");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule